// File: doc/BRIEF.md
# Timer-Triggered Dual SPI ADC Sampler

This block reads two external SPI-style ADCs on a fixed schedule without any processor involvement. A shared free-running sample timer counts from 0 up to a programmable wrap limit. Each ADC channel compares the timer with its own trigger value. On a match, the channel pulls that ADC's active-low chip-select low, which starts the conversion inside the ADC. The channel then holds the serial clock low for a programmable setup time, and shifts the 16-bit result in on a receive-only data line.

Each completed read is presented as a parallel word with a one-cycle valid strobe. Because each channel has its own trigger value, the two conversions can be offset by a known number of timer counts. Nothing is sampled until the enable input is raised. A trigger that arrives while a channel is still busy is dropped, and it sets a sticky overrun flag for that channel.

Top module: `adc_sampler_top`

## Requirements
- R1: After reset, every chip-select is high, every serial clock is low, and no sample-valid or overrun flag is set.
- R2: While `enable` is low, no chip-select falls, whatever the trigger values.
- R3: With the timer enabled in cycle e, a channel whose trigger value c is within the wrap limit drives chip-select low first in cycle e+c+1. A trigger value above the wrap limit never starts a read.
- R4: While enabled, consecutive chip-select falls of one channel are exactly wrap limit + 1 cycles apart.
- R5: The first falls of the two channels differ by exactly the difference of their trigger values.
- R6: After chip-select falls, the serial clock stays low for exactly S+1+CLK_DIV/2 cycles before its first rising edge, where S is `setup_cycles`.
- R7: A read has exactly 16 rising serial clock edges. The serial clock is low whenever chip-select is high.
- R8: Bits are captured at the system edge that raises the serial clock, most significant bit first. `sample_data` equals the 16-bit word the ADC shifted out.
- R9: Chip-select stays low for exactly S+1+16·CLK_DIV cycles. It returns high in the same cycle that the sample-valid strobe is high.
- R10: Sample-valid is a one-cycle pulse. `sample_data` changes only in a cycle where sample-valid is high.
- R11: A trigger during a read is ignored: the read runs its normal length with correct data, and that channel's overrun flag is set. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the sample timer; low holds it at zero |
| period | input | TIMER_W | Timer wrap limit (timer counts 0..period) |
| cmp_val | input | N_ADC×TIMER_W | Per-channel trigger value |
| setup_cycles | input | SETUP_W | Conversion setup wait in system cycles |
| miso | input | N_ADC | Serial data from each ADC |
| cs_n | output | N_ADC | Active-low chip-select / convert per ADC |
| sclk | output | N_ADC | Serial clock per ADC, idles low |
| sample_data | output | N_ADC×16 | Last received word per channel |
| sample_valid | output | N_ADC | One-cycle strobe per completed read |
| overrun | output | N_ADC | Sticky flag: trigger seen while busy |

## Verification
A trigger seen with the timer at value c appears as a chip-select fall one cycle later. From that fall, the first serial rising edge is due S+1+CLK_DIV/2 cycles later, and chip-select returns high together with the valid strobe S+1+16·CLK_DIV cycles after the fall. The bench samples at the falling clock edge and counts cycles from each observed chip-select fall, so every check compares the cycle distance it measured against these closed-form values. The settings swept are setup values 0, 1, 5 and 12, several trigger pairs, and an out-of-range trigger. The bench's own ADC model drives the data and changes a bit only after a serial-clock fall, so the expected word is known for each read.

// File: rtl/adc_sampler_pkg.sv
package adc_sampler_pkg;

    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_SETUP = 2'd1,
        RD_SHIFT = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                valid;
    } sample_t;

    // Half of the serial-clock period spent low (rounded down, at least 1 for div>=2).
    function automatic int low_phase(input int div);
        return div / 2;
    endfunction

endpackage

// File: rtl/sample_timer.sv
module sample_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [TIMER_W-1:0] period,
    output logic [TIMER_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            count <= '0;
        end else if (count >= period) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/compare_trigger.sv
module compare_trigger #(
    parameter int TIMER_W = 16
) (
    input  logic               enable,
    input  logic [TIMER_W-1:0] count,
    input  logic [TIMER_W-1:0] match_val,
    output logic               hit
);
    always_comb hit = enable && (count == match_val);
endmodule

// File: rtl/adc_read_channel.sv
module adc_read_channel
    import adc_sampler_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int SETUP_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit,
    input  logic [SETUP_W-1:0] setup_cycles,
    input  logic               miso,
    output logic               cs_n,
    output logic               sclk,
    output sample_t            sample,
    output logic               overrun
);
    localparam int PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(SAMPLE_W);
    localparam int LO    = low_phase(CLK_DIV);

    rd_state_e             state;
    logic [SETUP_W-1:0]    wait_cnt;
    logic [PH_W-1:0]       phase;
    logic [BIT_W-1:0]      bit_idx;
    logic [SAMPLE_W-1:0]   shreg;
    logic                  sclk_q;
    sample_t               out_q;
    logic                  ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RD_IDLE;
            wait_cnt <= '0;
            phase    <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            sclk_q   <= 1'b0;
            out_q    <= '0;
            ovr_q    <= 1'b0;
        end else begin
            out_q.valid <= 1'b0;
            if (hit && state != RD_IDLE) begin
                ovr_q <= 1'b1;
            end
            unique case (state)
                RD_IDLE: begin
                    sclk_q <= 1'b0;
                    if (hit) begin
                        state    <= RD_SETUP;
                        wait_cnt <= '0;
                    end
                end
                RD_SETUP: begin
                    if (wait_cnt == setup_cycles) begin
                        state   <= RD_SHIFT;
                        phase   <= '0;
                        bit_idx <= '0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                RD_SHIFT: begin
                    if (phase == PH_W'(LO - 1)) begin
                        sclk_q <= 1'b1;
                        shreg  <= {shreg[SAMPLE_W-2:0], miso};
                    end
                    if (phase == PH_W'(CLK_DIV - 1)) begin
                        sclk_q <= 1'b0;
                        phase  <= '0;
                        if (bit_idx == BIT_W'(SAMPLE_W - 1)) begin
                            state       <= RD_IDLE;
                            out_q.data  <= shreg;
                            out_q.valid <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    always_comb begin
        cs_n    = (state == RD_IDLE);
        sclk    = sclk_q;
        sample  = out_q;
        overrun = ovr_q;
    end
endmodule

// File: rtl/adc_sampler_top.sv
module adc_sampler_top
    import adc_sampler_pkg::*;
#(
    parameter int N_ADC   = 2,
    parameter int TIMER_W = 16,
    parameter int SETUP_W = 8,
    parameter int CLK_DIV = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              enable,
    input  logic [TIMER_W-1:0]                period,
    input  logic [N_ADC-1:0][TIMER_W-1:0]     cmp_val,
    input  logic [SETUP_W-1:0]                setup_cycles,
    input  logic [N_ADC-1:0]                  miso,
    output logic [N_ADC-1:0]                  cs_n,
    output logic [N_ADC-1:0]                  sclk,
    output logic [N_ADC-1:0][SAMPLE_W-1:0]    sample_data,
    output logic [N_ADC-1:0]                  sample_valid,
    output logic [N_ADC-1:0]                  overrun
);
    logic [TIMER_W-1:0] tcount;

    sample_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .period (period),
        .count  (tcount)
    );

    for (genvar g = 0; g < N_ADC; g++) begin : g_ch
        logic    hit;
        sample_t smp;

        compare_trigger #(.TIMER_W(TIMER_W)) u_cmp (
            .enable    (enable),
            .count     (tcount),
            .match_val (cmp_val[g]),
            .hit       (hit)
        );

        adc_read_channel #(.CLK_DIV(CLK_DIV), .SETUP_W(SETUP_W)) u_rd (
            .clk          (clk),
            .rst          (rst),
            .hit          (hit),
            .setup_cycles (setup_cycles),
            .miso         (miso[g]),
            .cs_n         (cs_n[g]),
            .sclk         (sclk[g]),
            .sample       (smp),
            .overrun      (overrun[g])
        );

        assign sample_data[g]  = smp.data;
        assign sample_valid[g] = smp.valid;
    end
endmodule

// File: rtl/adc_sampler_chk.sv
module adc_sampler_chk #(
    parameter int N_ADC    = 2,
    parameter int SAMPLE_W = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           enable,
    input logic [N_ADC-1:0]               cs_n,
    input logic [N_ADC-1:0]               sclk,
    input logic [N_ADC-1:0][SAMPLE_W-1:0] sample_data,
    input logic [N_ADC-1:0]               sample_valid,
    input logic [N_ADC-1:0]               overrun
);
    for (genvar g = 0; g < N_ADC; g++) begin : g_a
        p_sclk_idle_r7: assert property (@(posedge clk) disable iff (rst)
            cs_n[g] |-> !sclk[g]);
        p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
            sample_valid[g] |=> !sample_valid[g]);
        p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
            !$stable(sample_data[g]) |-> sample_valid[g]);
        p_cs_rise_valid_r9: assert property (@(posedge clk) disable iff (rst)
            $rose(cs_n[g]) |-> sample_valid[g]);
        p_start_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
            $fell(cs_n[g]) |-> $past(enable));
        p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (rst)
            overrun[g] |=> overrun[g]);
    end
endmodule

bind adc_sampler_top adc_sampler_chk #(.N_ADC(N_ADC), .SAMPLE_W(16)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .sample_data  (sample_data),
    .sample_valid (sample_valid),
    .overrun      (overrun)
);

// File: tb/sim_adc_sampler_top.sv
module sim_adc_sampler_top;
    localparam int DIV = 4;
    localparam int LO  = DIV / 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic [15:0]      period = 16'd99;
    logic [1:0][15:0] cmp_val = '0;
    logic [7:0]       setup_cycles = 8'd0;
    logic [1:0]       miso = '0;
    logic [1:0]       cs_n, sclk, sample_valid, overrun;
    logic [1:0][15:0] sample_data;

    adc_sampler_top #(.N_ADC(2), .TIMER_W(16), .SETUP_W(8), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .period(period), .cmp_val(cmp_val),
        .setup_cycles(setup_cycles), .miso(miso), .cs_n(cs_n), .sclk(sclk),
        .sample_data(sample_data), .sample_valid(sample_valid), .overrun(overrun)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] gen_word(input int ch, input int n);
        return 16'hB38E ^ 16'(n * 16'h2F1D) ^ (ch != 0 ? 16'h5A5A : 16'h0000);
    endfunction

    // monitor and ADC model state
    int         nfall [2];
    int         nval [2];
    int         low_cnt [2];
    int         pre [2];
    int         rises [2];
    bit         risen [2];
    int         bitpos [2];
    logic [15:0] word [2];
    bit         pcs [2];
    bit         psclk [2];
    bit         pv_valid [2];
    logic [15:0] pv_data [2];
    bit         armed [2];
    int         exp_first [2];
    int         first_fall [2];
    int         last_fall [2];
    bit         have_last [2];
    bit         chk_period = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            for (int ch = 0; ch < 2; ch++) begin
                nfall[ch] = 0; nval[ch] = 0; pcs[ch] = 1'b1; psclk[ch] = 1'b0;
                pv_valid[ch] = 1'b0; have_last[ch] = 1'b0; risen[ch] = 1'b0;
                miso[ch] = 1'b0; first_fall[ch] = -1;
            end
        end else begin
            for (int ch = 0; ch < 2; ch++) begin
                if (pv_valid[ch]) begin
                    check(!sample_valid[ch], "R10 valid pulse width", int'(sample_valid[ch]), 0);
                    check(sample_data[ch] == pv_data[ch], "R10 data held",
                          int'(sample_data[ch]), int'(pv_data[ch]));
                end
                pv_valid[ch] = sample_valid[ch];
                pv_data[ch]  = sample_data[ch];
                if (!cs_n[ch] && pcs[ch]) begin
                    word[ch]   = gen_word(ch, nfall[ch]);
                    nfall[ch]++;
                    bitpos[ch] = 15;
                    miso[ch]   = word[ch][15];
                    low_cnt[ch] = 0; pre[ch] = 0; rises[ch] = 0; risen[ch] = 1'b0;
                    if (armed[ch]) begin
                        check(cyc == exp_first[ch], "R3 first fall cycle", cyc, exp_first[ch]);
                        armed[ch] = 1'b0;
                        first_fall[ch] = cyc;
                    end
                    if (chk_period && have_last[ch])
                        check(cyc - last_fall[ch] == int'(period) + 1, "R4 trigger spacing",
                              cyc - last_fall[ch], int'(period) + 1);
                    last_fall[ch] = cyc;
                    have_last[ch] = 1'b1;
                end
                if (!cs_n[ch]) begin
                    low_cnt[ch]++;
                    if (sclk[ch] && !psclk[ch]) begin
                        rises[ch]++;
                        if (!risen[ch]) begin
                            check(pre[ch] == int'(setup_cycles) + 1 + LO, "R6 setup wait",
                                  pre[ch], int'(setup_cycles) + 1 + LO);
                            risen[ch] = 1'b1;
                        end
                    end
                    if (!sclk[ch] && !risen[ch]) pre[ch]++;
                    if (!sclk[ch] && psclk[ch] && bitpos[ch] > 0) begin
                        bitpos[ch]--;
                        miso[ch] = word[ch][bitpos[ch]];
                    end
                end
                if (cs_n[ch] && !pcs[ch]) begin
                    nval[ch]++;
                    check(sample_valid[ch], "R9 valid with cs rise", int'(sample_valid[ch]), 1);
                    check(low_cnt[ch] == int'(setup_cycles) + 1 + 16 * DIV, "R9 cs low length",
                          low_cnt[ch], int'(setup_cycles) + 1 + 16 * DIV);
                    check(rises[ch] == 16, "R7 sclk rising edges", rises[ch], 16);
                    check(!sclk[ch], "R7 sclk idle low", int'(sclk[ch]), 0);
                    check(sample_data[ch] == word[ch], "R8 sample word",
                          int'(sample_data[ch]), int'(word[ch]));
                end
                pcs[ch]   = cs_n[ch];
                psclk[ch] = sclk[ch];
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        enable = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Enable for three timer periods, then drain.
    task automatic run_cfg(input int s, input int c0, input int c1, input int exp_reads0,
                           input int exp_reads1);
        do_reset();
        setup_cycles = 8'(s);
        cmp_val[0] = 16'(c0);
        cmp_val[1] = 16'(c1);
        armed[0] = (exp_reads0 > 0);
        armed[1] = (exp_reads1 > 0);
        exp_first[0] = cyc + c0 + 1;
        exp_first[1] = cyc + c1 + 1;
        enable = 1'b1;
        repeat (3 * (int'(period) + 1)) @(negedge clk);
        enable = 1'b0;
        repeat (int'(period) + 20) @(negedge clk);
        check(nval[0] == exp_reads0, "R3 reads on ch0", nval[0], exp_reads0);
        check(nval[1] == exp_reads1, "R3 reads on ch1", nval[1], exp_reads1);
        if (exp_reads0 > 0 && exp_reads1 > 0)
            check(first_fall[1] - first_fall[0] == c1 - c0, "R5 channel skew",
                  first_fall[1] - first_fall[0], c1 - c0);
        check(overrun == 2'b00, "R11 no overrun when spaced", int'(overrun), 0);
    endtask

    initial begin
        int setups [4] = '{0, 1, 5, 12};
        // R1 reset state
        do_reset();
        check(cs_n == 2'b11, "R1 cs_n after reset", int'(cs_n), 3);
        check(sclk == 2'b00, "R1 sclk after reset", int'(sclk), 0);
        check(sample_valid == 2'b00, "R1 valid after reset", int'(sample_valid), 0);
        check(overrun == 2'b00, "R1 overrun after reset", int'(overrun), 0);

        // R2 disabled: no conversions
        cmp_val[0] = 16'd0;
        cmp_val[1] = 16'd1;
        repeat (300) @(negedge clk);
        check(nfall[0] == 0 && nfall[1] == 0, "R2 no cs fall while disabled",
              nfall[0] + nfall[1], 0);

        // sweep of setup times and trigger pairs
        period = 16'd99;
        chk_period = 1'b1;
        for (int i = 0; i < 4; i++) begin
            run_cfg(setups[i], 0, 1, 3, 3);
            run_cfg(setups[i], 3, 3, 3, 3);
            run_cfg(setups[i], 10, 40, 3, 3);
        end
        // trigger value above wrap limit never fires (R3)
        run_cfg(2, 5, 150, 3, 0);

        // R11 overrun: triggers faster than one read
        do_reset();
        chk_period = 1'b0;
        period = 16'd30;
        setup_cycles = 8'd2;
        cmp_val[0] = 16'd0;
        cmp_val[1] = 16'd7;
        enable = 1'b1;
        repeat (200) @(negedge clk);
        enable = 1'b0;
        repeat (100) @(negedge clk);
        check(overrun == 2'b11, "R11 overrun set", int'(overrun), 3);
        check(nval[0] == nfall[0] && nval[0] >= 2, "R11 reads complete normally", nval[0], nfall[0]);
        repeat (50) @(negedge clk);
        check(overrun == 2'b11, "R11 overrun sticky", int'(overrun), 3);
        do_reset();
        check(overrun == 2'b00, "R1 overrun cleared by reset", int'(overrun), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule